// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A single-port static memory model with a registered front end and a registered read path. Every input is sampled on the rising clock edge. An access begins when one of two active-low address strobes is low while the part is selected. The starting address is then loaded into a burst unit. On later cycles an active-low step input moves a 2-bit counter, which generates up to four word addresses inside the aligned group of four words. The counter visits them in linear order or in XOR-interleaved order, as chosen by an order input.

Writes can cover the whole word through a global write input. They can also cover selected byte lanes, through per-lane enables that count only while a byte-write qualifier is low. Read data leaves through an output register. The data bus is reported as driven only while the output-enable input is low and the output register holds read data. Depth, lane count and lane width are parameters. Setting ADDR_W to 16 gives the 64K x 32 arrangement.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, rdata_oe_o is 0 and rdata_o is all zeros.
- R2: An access starts only if sel0_ni=0, sel1_i=1 and sel2_ni=0. A strobe that is low while this condition fails ends the burst. Later cycles without a strobe then make no access, so no read data appears.
- R3: cpu_strb_ni is ignored while sel0_ni=1. In that case the burst continues as if no strobe were present.
- R4: A start made by cpu_strb_ni is always a read, whatever the write inputs are. cpu_strb_ni takes priority over ctl_strb_ni when both are low.
- R5: A start made by ctl_strb_ni, with a write requested, writes wdata_i at addr_i.
- R6: In linear order (order_i=0), each cycle with no strobe and step_ni=0 accesses the address whose low two bits are start+count mod 4. The upper address bits stay at those of the start address.
- R7: In interleaved order (order_i=1), the low two bits are start XOR count, for count = 1, 2, 3.
- R8: A cycle with no strobe and step_ni=1 repeats the previous address.
- R9: wr_all_ni=0 writes all lanes, whatever wr_byte_ni and lane_en_ni are.
- R10: If wr_all_ni=1 and wr_byte_ni=0, the write covers only the lanes i where lane_en_ni[i]=0. Lane i is bits 8i+7:8i. If wr_byte_ni=1 and wr_all_ni=1, the cycle is a read and lane_en_ni has no effect.
- R11: Read data for an address captured at edge k is on rdata_o after edge k+1. rdata_oe_o=1 only while out_en_ni=0 and that data is a read result. Otherwise rdata_o is zero.
- R12: A read issued in the cycle right after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel0_ni | input | 1 | Chip select, active low; also gates cpu_strb_ni |
| sel1_i | input | 1 | Chip select, active high |
| sel2_ni | input | 1 | Chip select, active low |
| cpu_strb_ni | input | 1 | Address strobe, read-only start, priority |
| ctl_strb_ni | input | 1 | Address strobe, read or write start |
| step_ni | input | 1 | Burst advance, active low |
| order_i | input | 1 | 0 linear, 1 interleaved |
| wr_all_ni | input | 1 | Global write, active low |
| wr_byte_ni | input | 1 | Byte-write qualifier, active low |
| lane_en_ni | input | NUM_BYTES | Per-lane write enables, active low |
| out_en_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | NUM_BYTES*BYTE_W | Write data |
| rdata_o | output | NUM_BYTES*BYTE_W | Read data, zero when not driven |
| rdata_oe_o | output | 1 | Data bus drive indication |

## Verification
The bench builds the block with ADDR_W=8, four lanes of 8 bits. This keeps the array small while still giving a full four-word group at 0x10..0x13. Starting at 0x12 and at 0x13 makes both orderings wrap around the group boundary. With four lanes, a mask of alternating enabled lanes can be read back against untouched neighbours.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_DESEL = 2'd1,
    CYC_START = 2'd2,
    CYC_CONT  = 2'd3
  } cyc_e;

  // low two address bits for a burst step
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] count,
                                           input logic       ilv);
    return ilv ? (start ^ count) : (start + count);
  endfunction

endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_strb_ni,
  input  logic              ctl_strb_ni,
  input  logic              step_ni,
  input  logic              sel0_ni,
  input  logic              sel1_i,
  input  logic              sel2_ni,
  input  logic              order_i,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              acc_valid_o,
  output logic              acc_write_o,
  output logic [ADDR_W-1:0] acc_addr_o
);

  logic              active_q, active_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_q, cnt_d;
  logic              acc_v_q, acc_v_d;
  logic              acc_w_q, acc_w_d;
  logic [ADDR_W-1:0] acc_a_q, acc_a_d;
  logic              sel, cpu_go, ctl_go;
  cyc_e              cyc;

  always_comb begin
    sel    = !sel0_ni && sel1_i && !sel2_ni;
    cpu_go = !cpu_strb_ni && !sel0_ni;
    ctl_go = !ctl_strb_ni && !cpu_go;

    if (cpu_go || ctl_go) cyc = sel ? CYC_START : CYC_DESEL;
    else if (active_q)    cyc = CYC_CONT;
    else                  cyc = CYC_IDLE;

    active_d = active_q;
    base_d   = base_q;
    cnt_d    = cnt_q;
    acc_v_d  = 1'b0;
    acc_w_d  = 1'b0;
    acc_a_d  = acc_a_q;

    unique case (cyc)
      CYC_START: begin
        active_d = 1'b1;
        base_d   = addr_i;
        cnt_d    = 2'd0;
        acc_v_d  = 1'b1;
        acc_w_d  = ctl_go && wr_req_i;
        acc_a_d  = addr_i;
      end
      CYC_DESEL: active_d = 1'b0;
      CYC_CONT: begin
        cnt_d   = step_ni ? cnt_q : cnt_q + 2'd1;
        acc_v_d = 1'b1;
        acc_w_d = wr_req_i;
        acc_a_d = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_d, order_i)};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      acc_v_q  <= 1'b0;
      acc_w_q  <= 1'b0;
      acc_a_q  <= '0;
    end else begin
      active_q <= active_d;
      base_q   <= base_d;
      cnt_q    <= cnt_d;
      acc_v_q  <= acc_v_d;
      acc_w_q  <= acc_w_d;
      acc_a_q  <= acc_a_d;
    end
  end

  assign acc_valid_o = acc_v_q;
  assign acc_write_o = acc_w_q;
  assign acc_addr_o  = acc_a_q;

  // R2: a deselecting strobe leaves no burst behind
  a_r2_desel_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_strb_ni && cpu_strb_ni && !(!sel0_ni && sel1_i && !sel2_ni))
      |=> (!active_q && !acc_v_q));

  // R4: processor-side start is a read
  a_r4_cpu_start_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_strb_ni && !sel0_ni && sel1_i && !sel2_ni) |=> (acc_v_q && !acc_w_q));

  // R6: linear step moves the low bits by one
  a_r6_linear_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cpu_strb_ni && ctl_strb_ni && !step_ni && !order_i && $past(!order_i))
      |=> (acc_a_q[1:0] == $past(acc_a_q[1:0]) + 2'd1));

  // R8: no step, same address
  a_r8_hold_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cpu_strb_ni && ctl_strb_ni && step_ni && (order_i == $past(order_i)))
      |=> (acc_a_q == $past(acc_a_q)));

endmodule

// File: rtl/sbs_lane_ctl.sv
module sbs_lane_ctl #(
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 8,
  localparam int DATA_W   = NUM_BYTES * BYTE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_all_ni,
  input  logic                 wr_byte_ni,
  input  logic [NUM_BYTES-1:0] lane_en_ni,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic                 wr_req_o,
  output logic [NUM_BYTES-1:0] lane_we_o,
  output logic [DATA_W-1:0]    wdata_o
);

  logic [NUM_BYTES-1:0] lane_we_d;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    assign lane_we_d[g] = !wr_all_ni || (!wr_byte_ni && !lane_en_ni[g]);
  end

  // qualifier low with no lanes enabled still counts as a write cycle
  assign wr_req_o = !wr_all_ni || !wr_byte_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_we_o <= '0;
      wdata_o   <= '0;
    end else begin
      lane_we_o <= lane_we_d;
      wdata_o   <= wdata_i;
    end
  end

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int ADDR_W    = 10,
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 8,
  localparam int DEPTH    = 1 << ADDR_W,
  localparam int DATA_W   = NUM_BYTES * BYTE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 acc_valid_i,
  input  logic                 acc_write_i,
  input  logic [ADDR_W-1:0]    acc_addr_i,
  input  logic [NUM_BYTES-1:0] lane_we_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic                 rd_valid_o,
  output logic [DATA_W-1:0]    rd_data_o
);

  logic do_rd, do_wr;
  assign do_rd = acc_valid_i && !acc_write_i;
  assign do_wr = acc_valid_i &&  acc_write_i;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];
    logic [BYTE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (do_wr && lane_we_i[g]) lane_mem[acc_addr_i] <= wdata_i[g*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    rd_q <= '0;
      else if (do_rd) rd_q <= lane_mem[acc_addr_i];
    end

    assign rd_data_o[g*BYTE_W +: BYTE_W] = rd_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_valid_o <= 1'b0;
    else         rd_valid_o <= do_rd;
  end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W    = 10,
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 8,
  localparam int DATA_W   = NUM_BYTES * BYTE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sel0_ni,
  input  logic                 sel1_i,
  input  logic                 sel2_ni,
  input  logic                 cpu_strb_ni,
  input  logic                 ctl_strb_ni,
  input  logic                 step_ni,
  input  logic                 order_i,
  input  logic                 wr_all_ni,
  input  logic                 wr_byte_ni,
  input  logic [NUM_BYTES-1:0] lane_en_ni,
  input  logic                 out_en_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 rdata_oe_o
);

  logic                 wr_req;
  logic [NUM_BYTES-1:0] lane_we;
  logic [DATA_W-1:0]    wdata_q;
  logic                 acc_valid, acc_write;
  logic [ADDR_W-1:0]    acc_addr;
  logic                 rd_valid;
  logic [DATA_W-1:0]    rd_data;

  sbs_lane_ctl #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_lane (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_all_ni  (wr_all_ni),
    .wr_byte_ni (wr_byte_ni),
    .lane_en_ni (lane_en_ni),
    .wdata_i    (wdata_i),
    .wr_req_o   (wr_req),
    .lane_we_o  (lane_we),
    .wdata_o    (wdata_q)
  );

  sbs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_strb_ni (cpu_strb_ni),
    .ctl_strb_ni (ctl_strb_ni),
    .step_ni     (step_ni),
    .sel0_ni     (sel0_ni),
    .sel1_i      (sel1_i),
    .sel2_ni     (sel2_ni),
    .order_i     (order_i),
    .wr_req_i    (wr_req),
    .addr_i      (addr_i),
    .acc_valid_o (acc_valid),
    .acc_write_o (acc_write),
    .acc_addr_o  (acc_addr)
  );

  sbs_array #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_valid_i (acc_valid),
    .acc_write_i (acc_write),
    .acc_addr_i  (acc_addr),
    .lane_we_i   (lane_we),
    .wdata_i     (wdata_q),
    .rd_valid_o  (rd_valid),
    .rd_data_o   (rd_data)
  );

  assign rdata_oe_o = rd_valid && !out_en_ni;
  assign rdata_o    = rdata_oe_o ? rd_data : '0;

  // R11: output register holds data only from a read access one cycle earlier
  a_r11_rd_follows_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid |-> $past(acc_valid && !acc_write));

endmodule

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb;

  localparam int AW = 8;
  localparam int NB = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel0_n, sel1, sel2_n, cpu_n, ctl_n, step_n, ord, all_n, byte_n, oe_n;
  logic [NB-1:0] lane_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wd;
  logic [DW-1:0] rdata;
  logic          rdata_oe;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW), .NUM_BYTES(NB), .BYTE_W(8)) u_dut (
    .clk_i (clk), .rst_ni (rst_n),
    .sel0_ni (sel0_n), .sel1_i (sel1), .sel2_ni (sel2_n),
    .cpu_strb_ni (cpu_n), .ctl_strb_ni (ctl_n), .step_ni (step_n),
    .order_i (ord), .wr_all_ni (all_n), .wr_byte_ni (byte_n),
    .lane_en_ni (lane_n), .out_en_ni (oe_n), .addr_i (addr),
    .wdata_i (wd), .rdata_o (rdata), .rdata_oe_o (rdata_oe)
  );

  typedef struct packed {
    logic          cpu_n;
    logic          ctl_n;
    logic          step_n;
    logic          all_n;
    logic          byte_n;
    logic [3:0]    lane_n;
    logic          ord;
    logic [7:0]    addr;
    logic [31:0]   wd;
    logic          rd;
    logic [31:0]   exp;
    logic [3:0]    req;
  } vec_t;

  localparam logic [31:0] W0 = 32'hA0A1A2A3, W1 = 32'hB0B1B2B3,
                          W2 = 32'hC0C1C2C3, W3 = 32'hD0D1D2D3;
  localparam logic [31:0] WM = 32'hA0BBA2BB;

  localparam vec_t TBL [17] = '{
    // R5 controller start writes, then R6 linear steps with wrap
    '{1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,8'h12,W0,1'b0,32'h0,4'd5},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,1'b0,8'h00,W1,1'b0,32'h0,4'd6},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,1'b0,8'h00,W2,1'b0,32'h0,4'd6},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,1'b0,8'h00,W3,1'b0,32'h0,4'd6},
    // R4 processor start with global write low still reads
    '{1'b0,1'b1,1'b1,1'b0,1'b1,4'hF,1'b0,8'h12,32'hFFFFFFFF,1'b1,W0,4'd4},
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,8'h00,32'h0,1'b1,W1,4'd6},
    // R8 hold
    '{1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,8'h00,32'h0,1'b1,W1,4'd8},
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,8'h00,32'h0,1'b1,W2,4'd6},
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,8'h00,32'h0,1'b1,W3,4'd6},
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,8'h00,32'h0,1'b1,W0,4'd6},
    // R7 interleaved from 0x13: 13,12,11,10
    '{1'b0,1'b1,1'b1,1'b1,1'b1,4'hF,1'b1,8'h13,32'h0,1'b1,W1,4'd7},
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,8'h00,32'h0,1'b1,W0,4'd7},
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,8'h00,32'h0,1'b1,W3,4'd7},
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,8'h00,32'h0,1'b1,W2,4'd7},
    // R10 lanes 0 and 2, then R12 immediate read, then qualifier high ignores lanes
    '{1'b1,1'b0,1'b1,1'b1,1'b0,4'hA,1'b0,8'h12,32'hBBBBBBBB,1'b0,32'h0,4'd10},
    '{1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,8'h12,32'h0,1'b1,WM,4'd12},
    '{1'b1,1'b0,1'b1,1'b1,1'b1,4'h0,1'b0,8'h12,32'h77777777,1'b1,WM,4'd10}
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    sel0_n = 1'b0; sel1 = 1'b1; sel2_n = 1'b0;
    cpu_n = 1'b1; ctl_n = 1'b1; step_n = 1'b1; ord = 1'b0;
    all_n = 1'b1; byte_n = 1'b1; lane_n = '1; oe_n = 1'b0;
    addr = '0; wd = '0;
  endtask

  task automatic chk(input string req, input logic oe_a, input logic [31:0] d_a,
                     input logic oe_e, input logic [31:0] d_e);
    n_run++;
    if (oe_a !== oe_e || d_a !== d_e) begin
      n_fail++;
      $display("FAIL %s: oe=%0b data=%h, expected oe=%0b data=%h", req, oe_a, d_a, oe_e, d_e);
    end
  endtask

  task automatic chk_vec(input vec_t v);
    chk($sformatf("R%0d", v.req), rdata_oe, rdata, v.rd, v.rd ? v.exp : 32'h0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    #45;
    chk("R1 reset", rdata_oe, rdata, 1'b0, 32'h0);
    rst_n = 1'b1;
    tick();
    chk("R1 idle after reset", rdata_oe, rdata, 1'b0, 32'h0);

    for (int i = 0; i < 17; i++) begin
      cpu_n = TBL[i].cpu_n; ctl_n = TBL[i].ctl_n; step_n = TBL[i].step_n;
      all_n = TBL[i].all_n; byte_n = TBL[i].byte_n; lane_n = TBL[i].lane_n;
      ord = TBL[i].ord; addr = TBL[i].addr; wd = TBL[i].wd;
      tick();
      if (i > 0) chk_vec(TBL[i-1]);
    end
    idle();
    tick();
    chk_vec(TBL[16]);

    // R2: deselect by sel1_i low ends the burst
    idle(); ctl_n = 1'b0; sel1 = 1'b0; addr = 8'h12;
    tick();
    idle(); step_n = 1'b0;
    tick();
    chk("R2 deselect cycle", rdata_oe, rdata, 1'b0, 32'h0);
    tick();
    chk("R2 no access after deselect", rdata_oe, rdata, 1'b0, 32'h0);

    // R2: sel2_ni high blocks a start
    idle(); ctl_n = 1'b0; sel2_n = 1'b1; addr = 8'h10;
    tick();
    idle();
    tick();
    chk("R2 sel2 blocks start", rdata_oe, rdata, 1'b0, 32'h0);

    // R3: processor strobe ignored while sel0_ni high
    idle(); cpu_n = 1'b0; addr = 8'h12;
    tick();
    idle(); cpu_n = 1'b0; sel0_n = 1'b1; step_n = 1'b0; addr = 8'h30;
    tick();
    chk("R11 read latency", rdata_oe, rdata, 1'b1, WM);
    idle();
    tick();
    chk("R3 strobe ignored, burst stepped", rdata_oe, rdata, 1'b1, W1);

    // R11: output enable gating
    idle(); cpu_n = 1'b0; addr = 8'h10; oe_n = 1'b1;
    tick();
    idle(); oe_n = 1'b1;
    tick();
    chk("R11 oe high quiet", rdata_oe, rdata, 1'b0, 32'h0);
    oe_n = 1'b0;
    #1;
    chk("R11 oe low drives", rdata_oe, rdata, 1'b1, W2);

    // R4 priority over controller strobe, then R9 global write
    idle(); cpu_n = 1'b0; ctl_n = 1'b0; all_n = 1'b0; addr = 8'h11; wd = 32'h12345678;
    tick();
    idle(); ctl_n = 1'b0; all_n = 1'b0; byte_n = 1'b0; lane_n = 4'hF; addr = 8'h11;
    wd = 32'hEEEEEEEE;
    tick();
    chk("R4 priority read, no write", rdata_oe, rdata, 1'b1, W3);
    idle(); ctl_n = 1'b0; addr = 8'h11;
    tick();
    chk("R9 write cycle not driven", rdata_oe, rdata, 1'b0, 32'h0);
    idle();
    tick();
    chk("R9 global write all lanes", rdata_oe, rdata, 1'b1, 32'hEEEEEEEE);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule